// File: doc/BRIEF.md
# Dead-Band PWM Leg with Safe Compare Update

This block drives one half-bridge leg from a 16-bit up-counting PWM. A counter runs from zero up to a programmable period and wraps, so one PWM cycle lasts period+1 clocks. A raw PWM level is high while the count is below the active compare value. The raw level is split into two complementary phase drives. Whenever the raw level changes, the phase that is about to switch on is held off for a programmable number of clocks. This dead band keeps the two switches of the leg from conducting together.

The compare value reaches the counter through one of two paths. Software-style writes land in a shadow register. A separate buffer register can be armed by a hardware trigger pulse, so an external event can change the duty without software. Both paths are committed to the active compare only at a cycle boundary: the wrap from period to zero, or a hardware restart. A compare change therefore never shortens, doubles or stretches a pulse inside a running cycle. A terminal-count pulse marks the last clock of every cycle, so a control loop can be paced by the PWM rather than by a free-running timer.

Top module: `dbpwm_leg`

## Requirements
- R1: The count runs 0,1,…,period and then returns to 0, so a cycle lasts period+1 clocks. `tcPulse` is high for exactly the one clock whose count equals the period.
- R2: The raw PWM level is high while the count is strictly below the active compare value and low otherwise.
- R3: A pulse on `cmpWrValid` stores `cmpWrData` in a shadow register. The shadow value becomes active only at the next wrap, so the cycle running during the write keeps its old duty. If several writes arrive before that wrap, the last one is used.
- R4: A pulse on `bufWrValid` stores `bufWrData` in a buffer register; on its own this has no effect on the outputs. A pulse on `trigPulse` makes the buffer value active at the next wrap. A trigger takes priority over a pending shadow write, and that shadow write is dropped.
- R5: After every change of the raw level, the phase that turns on stays low for `deadBand` clocks. For a compare value c with 0 < c ≤ period, `phaseHi` is high for max(0, c−deadBand) clocks and `phaseLo` for max(0, period+1−c−deadBand) clocks per cycle.
- R6: `phaseHi` and `phaseLo` are never high together. Whenever either one rises, both have been low for at least `deadBand` clocks just before.
- R7: A compare of 0 holds `phaseLo` high for the whole cycle. A compare greater than the period holds `phaseHi` high for the whole cycle. No dead-band gap is inserted in either case.
- R8: When the high or low interval is not longer than the dead band, the matching phase stays low for the whole interval.
- R9: While `restart` is high, both phases are low. The clock edge that samples it clears the count to 0, commits any pending compare update, and starts a new dead band. The next `tcPulse` follows period clocks after the first clock of the new cycle.
- R10: After reset the count is 0, the active compare is 0, nothing is pending, and both phases are low for the first `deadBand` clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| period | input | 16 | Last count value of a cycle |
| deadBand | input | 8 | Dead time in clocks |
| cmpWrValid | input | 1 | Shadow compare write strobe |
| cmpWrData | input | 16 | Shadow compare value |
| bufWrValid | input | 1 | Buffer compare write strobe |
| bufWrData | input | 16 | Buffer compare value |
| trigPulse | input | 1 | Hardware trigger: use buffer at next wrap |
| restart | input | 1 | Synchronous restart of the cycle |
| phaseHi | output | 1 | High-side phase drive |
| phaseLo | output | 1 | Low-side phase drive |
| tcPulse | output | 1 | High on the last clock of each cycle |

## Verification
The assertions assume that `period` and `deadBand` stay constant except while the leg is idle or just after reset. The single-pulse terminal-count property and the dead-gap property are only meaningful while these settings are stable. The stimulus sets both settings at the start of each sweep section and does not change them inside a measured cycle. The compare writes, trigger and restart are issued away from the terminal-count clock, so it is always clear which wrap commits them. The sweep covers every compare value from 0 to period+1 for dead bands of 0, 1 and 3 with a period of 9. Each measured cycle is the second one after the commit, so the transition from the previous duty has settled.

// File: rtl/dbpwm_pkg.sv
package dbpwm_pkg;
  // strobes from compare control to the counter datapath
  typedef struct packed {
    logic loadShadow;  // active compare <- shadow register
    logic loadBuffer;  // active compare <- buffer register
    logic clearCount;  // restart the cycle at count 0
  } cmpStrobe_t;
endpackage

// File: rtl/dbpwm_ctrl.sv
module dbpwm_ctrl
  import dbpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmpWrValid,
  input  logic [CNT_W-1:0] cmpWrData,
  input  logic             bufWrValid,
  input  logic [CNT_W-1:0] bufWrData,
  input  logic             trigPulse,
  input  logic             restart,
  input  logic             atWrap,
  output cmpStrobe_t       strobe,
  output logic [CNT_W-1:0] shadowQ,
  output logic [CNT_W-1:0] bufferQ
);
  logic shadowPend;
  logic trigPend;
  logic commit;

  // a cycle boundary is the only safe point to change the compare
  assign commit = atWrap | restart;

  always_comb begin
    strobe.clearCount = restart;
    strobe.loadBuffer = commit & trigPend;
    strobe.loadShadow = commit & shadowPend & ~trigPend;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowQ    <= '0;
      bufferQ    <= '0;
      shadowPend <= 1'b0;
      trigPend   <= 1'b0;
    end else begin
      if (cmpWrValid) shadowQ <= cmpWrData;
      if (bufWrValid) bufferQ <= bufWrData;
      // a new request arriving on the commit edge waits for the next boundary
      if (cmpWrValid)  shadowPend <= 1'b1;
      else if (commit) shadowPend <= 1'b0;
      if (trigPulse)   trigPend <= 1'b1;
      else if (commit) trigPend <= 1'b0;
    end
  end
endmodule

// File: rtl/dbpwm_datapath.sv
module dbpwm_datapath
  import dbpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] period,
  input  cmpStrobe_t       strobe,
  input  logic [CNT_W-1:0] shadowQ,
  input  logic [CNT_W-1:0] bufferQ,
  output logic [CNT_W-1:0] cmpAct,
  output logic             atWrap,
  output logic             rawPwm
);
  logic [CNT_W-1:0] count;

  // >= also recovers if the period is lowered below the running count
  assign atWrap = (count >= period);
  assign rawPwm = (count < cmpAct);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count  <= '0;
      cmpAct <= '0;
    end else begin
      if (strobe.clearCount || atWrap) count <= '0;
      else                             count <= count + CNT_W'(1);
      if (strobe.loadBuffer)      cmpAct <= bufferQ;
      else if (strobe.loadShadow) cmpAct <= shadowQ;
    end
  end
endmodule

// File: rtl/dbpwm_deadband.sv
module dbpwm_deadband #(
  parameter int DB_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [DB_W-1:0] deadBand,
  input  logic            rawPwm,
  input  logic            restart,
  output logic            phaseHi,
  output logic            phaseLo
);
  localparam logic [DB_W-1:0] AGE_MAX = '1;

  logic            rawQ;
  logic [DB_W-1:0] age;      // clocks since the last raw edge, saturating
  logic            rawEdge;
  logic [DB_W-1:0] effAge;
  logic            onOk;

  assign rawEdge = rawPwm ^ rawQ;
  assign effAge  = rawEdge ? '0 : age;
  assign onOk    = (effAge >= deadBand);
  assign phaseHi = rawPwm & onOk & ~restart;
  assign phaseLo = ~rawPwm & onOk & ~restart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rawQ <= 1'b0;
      age  <= '0;
    end else begin
      rawQ <= rawPwm;
      if (restart)              age <= '0;
      else if (rawEdge)         age <= DB_W'(1);
      else if (age != AGE_MAX)  age <= age + DB_W'(1);
    end
  end
endmodule

// File: rtl/dbpwm_leg.sv
module dbpwm_leg
  import dbpwm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DB_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] period,
  input  logic [DB_W-1:0]  deadBand,
  input  logic             cmpWrValid,
  input  logic [CNT_W-1:0] cmpWrData,
  input  logic             bufWrValid,
  input  logic [CNT_W-1:0] bufWrData,
  input  logic             trigPulse,
  input  logic             restart,
  output logic             phaseHi,
  output logic             phaseLo,
  output logic             tcPulse
);
  cmpStrobe_t       strobe;
  logic [CNT_W-1:0] shadowQ;
  logic [CNT_W-1:0] bufferQ;
  logic [CNT_W-1:0] cmpAct;
  logic             atWrap;
  logic             rawPwm;

  assign tcPulse = atWrap;

  dbpwm_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cmpWrValid(cmpWrValid), .cmpWrData(cmpWrData),
    .bufWrValid(bufWrValid), .bufWrData(bufWrData),
    .trigPulse(trigPulse), .restart(restart), .atWrap(atWrap),
    .strobe(strobe), .shadowQ(shadowQ), .bufferQ(bufferQ)
  );

  dbpwm_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .period(period), .strobe(strobe),
    .shadowQ(shadowQ), .bufferQ(bufferQ),
    .cmpAct(cmpAct), .atWrap(atWrap), .rawPwm(rawPwm)
  );

  dbpwm_deadband #(.DB_W(DB_W)) u_db (
    .clk(clk), .rstN(rstN), .deadBand(deadBand), .rawPwm(rawPwm),
    .restart(restart), .phaseHi(phaseHi), .phaseLo(phaseLo)
  );
endmodule

// File: rtl/dbpwm_leg_chk.sv
module dbpwm_leg_chk #(
  parameter int CNT_W = 16,
  parameter int DB_W  = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] period,
  input logic [DB_W-1:0]  deadBand,
  input logic             restart,
  input logic             phaseHi,
  input logic             phaseLo,
  input logic             tcPulse,
  input logic [CNT_W-1:0] cmpAct
);
  localparam logic [DB_W:0] GAP_MAX = '1;

  // clocks for which both phases have been low, up to the previous clock
  logic [DB_W:0] gapCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 gapCnt <= '0;
    else if (phaseHi || phaseLo) gapCnt <= '0;
    else if (gapCnt != GAP_MAX) gapCnt <= gapCnt + 1'b1;
  end

  // R6: a phase turns on only after a full dead gap with both low
  p_dead_gap_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(phaseHi) || $rose(phaseLo)) |-> (gapCnt >= {1'b0, deadBand}));

  // R1: the terminal count is a single-clock pulse unless the period is 0
  p_tc_single_r1: assert property (@(posedge clk) disable iff (!rstN)
    (tcPulse && !restart) |=> (!tcPulse || period == '0));

  // R3, R4: the active compare moves only on a cycle boundary
  p_cmp_commit_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cmpAct) |-> $past(tcPulse || restart));

  // R9: the clock after a restart opens a fresh dead band
  p_restart_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(restart) && deadBand != '0) |-> (!phaseHi && !phaseLo));
endmodule

bind dbpwm_leg dbpwm_leg_chk #(.CNT_W(CNT_W), .DB_W(DB_W)) u_chk (
  .clk(clk), .rstN(rstN), .period(period), .deadBand(deadBand),
  .restart(restart), .phaseHi(phaseHi), .phaseLo(phaseLo),
  .tcPulse(tcPulse), .cmpAct(cmpAct)
);

// File: tb/test_dbpwm_leg.sv
module test_dbpwm_leg;
  localparam int P = 9;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] period = 16'(P);
  logic [7:0]  deadBand = 8'd3;
  logic        cmpWrValid = 1'b0;
  logic [15:0] cmpWrData = '0;
  logic        bufWrValid = 1'b0;
  logic [15:0] bufWrData = '0;
  logic        trigPulse = 1'b0;
  logic        restart = 1'b0;
  logic        phaseHi, phaseLo, tcPulse;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dbpwm_leg i_dbpwm_leg (
    .clk(clk), .rstN(rstN), .period(period), .deadBand(deadBand),
    .cmpWrValid(cmpWrValid), .cmpWrData(cmpWrData),
    .bufWrValid(bufWrValid), .bufWrData(bufWrData),
    .trigPulse(trigPulse), .restart(restart),
    .phaseHi(phaseHi), .phaseLo(phaseLo), .tcPulse(tcPulse)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int expHi(input int c, input int d);
    if (c == 0) return 0;
    if (c > P) return P + 1;
    return (c - d > 0) ? c - d : 0;
  endfunction

  function automatic int expLo(input int c, input int d);
    if (c == 0) return P + 1;
    if (c > P) return 0;
    return (P + 1 - c - d > 0) ? P + 1 - c - d : 0;
  endfunction

  task automatic waitTc();
    forever begin
      @(negedge clk);
      if (tcPulse) break;
    end
  endtask

  task automatic wrCmp(input int v);
    cmpWrData = 16'(v); cmpWrValid = 1'b1;
    @(negedge clk);
    cmpWrValid = 1'b0;
  endtask

  // counts one full cycle starting with the current sample (count 0)
  task automatic measure(output int hi, output int lo, output int tcs, output int ovl);
    hi = 0; lo = 0; tcs = 0; ovl = 0;
    for (int i = 0; i <= P; i++) begin
      if (i != 0) @(negedge clk);
      hi += int'(phaseHi); lo += int'(phaseLo);
      ovl += int'(phaseHi && phaseLo);
      if (tcPulse) tcs += (i == P) ? 1 : 100;
    end
  endtask

  initial begin
    int hi, lo, tcs, ovl;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R10: reset state
    check("R10 phaseHi after reset", int'(phaseHi), 0);
    check("R10 phaseLo after reset", int'(phaseLo), 0);
    check("R10 tcPulse after reset", int'(tcPulse), 0);
    @(negedge clk); @(negedge clk);
    check("R10 phaseLo inside first dead band", int'(phaseLo), 0);
    @(negedge clk);
    check("R10 phaseLo after first dead band", int'(phaseLo), 1);

    // sweep over dead band and every compare value
    foreach (deadBand[k]) begin end
    for (int di = 0; di < 3; di++) begin
      deadBand = (di == 0) ? 8'd0 : (di == 1) ? 8'd1 : 8'd3;
      for (int c = 0; c <= P + 1; c++) begin
        waitTc(); @(negedge clk); @(negedge clk);
        wrCmp(c);
        waitTc(); waitTc();
        @(negedge clk);
        measure(hi, lo, tcs, ovl);
        check($sformatf("R2 R5 R7 R8 phaseHi c=%0d d=%0d", c, deadBand), hi, expHi(c, int'(deadBand)));
        check($sformatf("R2 R5 R7 R8 phaseLo c=%0d d=%0d", c, deadBand), lo, expLo(c, int'(deadBand)));
        check($sformatf("R1 tc count c=%0d", c), tcs, 1);
        check($sformatf("R6 overlap c=%0d", c), ovl, 0);
      end
    end

    // R3: mid-cycle writes keep the running cycle; last write wins
    deadBand = 8'd1;
    waitTc(); @(negedge clk); @(negedge clk);
    wrCmp(4);
    waitTc(); waitTc();
    hi = 0;
    for (int i = 0; i <= P; i++) begin
      @(negedge clk);
      hi += int'(phaseHi);
      if (i == 3) begin
        cmpWrData = 16'd2; cmpWrValid = 1'b1;
        @(negedge clk); cmpWrValid = 1'b0; i++;
        hi += int'(phaseHi);
      end
      if (i == 6) begin
        cmpWrData = 16'd7; cmpWrValid = 1'b1;
        @(negedge clk); cmpWrValid = 1'b0; i++;
        hi += int'(phaseHi);
      end
    end
    check("R3 cycle during writes keeps old duty", hi, expHi(4, 1));
    @(negedge clk);
    measure(hi, lo, tcs, ovl);
    check("R3 last write wins", hi, expHi(7, 1));

    // R4: buffer write alone has no effect
    @(negedge clk); @(negedge clk);
    bufWrData = 16'd5; bufWrValid = 1'b1;
    @(negedge clk); bufWrValid = 1'b0;
    waitTc(); @(negedge clk);
    measure(hi, lo, tcs, ovl);
    check("R4 buffer without trigger ignored", hi, expHi(7, 1));

    // R4: trigger beats a pending shadow write, which is dropped
    @(negedge clk); @(negedge clk);
    wrCmp(2);
    trigPulse = 1'b1; @(negedge clk); trigPulse = 1'b0;
    waitTc(); @(negedge clk);
    measure(hi, lo, tcs, ovl);
    check("R4 trigger loads buffer", hi, expHi(5, 1));
    @(negedge clk);
    measure(hi, lo, tcs, ovl);
    check("R4 shadow write dropped", hi, expHi(5, 1));

    // R9: restart mid-cycle commits the pending write and restarts count
    deadBand = 8'd3;
    waitTc(); waitTc();
    @(negedge clk); @(negedge clk); @(negedge clk);
    wrCmp(6);
    restart = 1'b1;
    #1;
    check("R9 phases low during restart", int'(phaseHi || phaseLo), 0);
    @(negedge clk);
    restart = 1'b0;
    measure(hi, lo, tcs, ovl);
    check("R9 duty after restart", hi, expHi(6, 3));
    check("R9 low time after restart", lo, expLo(6, 3));
    check("R9 tc period clocks after restart", tcs, 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule